// File: doc/BRIEF.md
# Transmit Frame Buffer with Trigger and Completion Interrupt

This block sits between a host and the transmit side of a packet radio MAC. The host loads a frame image into a byte-addressed buffer of 128 bytes. The image begins with two prefix bytes: byte 0 carries the header length and byte 1 carries the payload length. The payload follows from byte 2. The host then writes the trigger bit of the control register. The block streams the image out on a byte-wide valid/ready interface. It presents the acknowledge-request choice as a sideband signal that stays steady for the whole frame.

After the last byte has been handed over, the block waits for a single pass/fail result from the downstream MAC. It records the result in a status bit and sets a completion flag in an interrupt status register. A maskable, active-low interrupt line reports the flag to the host. Reading the interrupt status register clears the flag. While a frame is in flight, buffer writes and control writes are discarded, so the image being sent cannot change under the stream.

Top module: `txq_frame_ctrl`

## Requirements
- R1: After reset, irq_no is 1 and tx_valid_o is 0. The control, TX status and interrupt status registers read 0, and the interrupt mask register reads 8'h01.
- R2: The stream carries buffer byte 0, then the (clamped) length byte, then payload bytes from address 2 upward. A frame holds 2 + length bytes, and tx_last_o is 1 only on the final byte.
- R3: A length byte above 126 is clamped: the stream sends 128 bytes, and its second byte is 126.
- R4: The register select encoding is 0 = control, 1 = TX status, 2 = interrupt status, 3 = interrupt mask. Read data appears on reg_rdata_o in the cycle after reg_re_i. A control write with bit 0 set starts a frame. Control bit 2 is the acknowledge request: it drives tx_ackreq_o and reads back in bit 2.
- R5: Control bit 0 (trigger) reads 1 from the start of a frame until its last byte is accepted, and 0 after that.
- R6: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o and tx_data_o hold their values.
- R7: A result (res_valid_i) is taken only after the last byte has been accepted, and only once per frame. TX status bit 0 then equals res_fail_i (1 means the retry count was exhausted). A result at any other time is ignored.
- R8: Interrupt status bit 0 is set when a result is taken. A read of the interrupt status register returns the old value and clears the bit. A result taken in the same cycle as such a read leaves the bit set.
- R9: irq_no is 0 exactly when interrupt status bit 0 is 1 and interrupt mask bit 0 is 0.
- R10: From the trigger until the result is taken, buffer writes and control writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_we_i | input | 1 | Buffer byte write strobe |
| buf_addr_i | input | 7 | Buffer byte address |
| buf_wdata_i | input | 8 | Buffer write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, one cycle after the read strobe |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream byte accepted by the MAC |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ackreq_o | output | 1 | Acknowledge request for the current frame |
| res_valid_i | input | 1 | Transmission result strobe |
| res_fail_i | input | 1 | Result: 1 means the retry count was exhausted |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Frames are sent under three readiness patterns:
- a short frame with the MAC always ready, which checks byte order and last-byte marking without stalls;
- an oversized length with pseudo-random back-pressure, which separates correct clamping and holding of data from dropped or repeated bytes;
- a minimal-length frame under masking, which exposes errors in the prefix-only case and in interrupt gating.

Results are injected in three situations: during sending, while idle, and in the same cycle as a status read. Together they tell a correct acceptance window and set-over-clear priority from a design that latches results too early or loses them. Writes issued during a frame must leave both the streamed bytes and the acknowledge sideband unchanged.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_TXSTAT = 2'd1,
    SEL_ISTAT  = 2'd2,
    SEL_IMASK  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } tx_state_e;

  localparam int CTRL_TRIG_BIT = 0;
  localparam int CTRL_ACK_BIT  = 2;
  localparam int PREFIX_BYTES  = 2;
endpackage

// File: rtl/txq_buf.sv
module txq_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] len_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
  assign len_o   = mem_q[1];
endmodule

// File: rtl/txq_stream.sv
module txq_stream
  import txq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] len_raw_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          tx_ready_i,
  input  logic          res_valid_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_last_o,
  output logic          frame_done_o,
  output logic          res_take_o,
  output logic          busy_o
);
  localparam int MAX_PAY = DEPTH - PREFIX_BYTES;
  localparam logic [DW-1:0] MAX_LEN = DW'(MAX_PAY);

  tx_state_e     state_q;
  logic [AW-1:0] ptr_q, last_q;
  logic [DW-1:0] len_q, len_c;

  assign len_c = (len_raw_i > MAX_LEN) ? MAX_LEN : len_raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      last_q  <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEND;
          ptr_q   <= '0;
          len_q   <= len_c;
          last_q  <= AW'(len_c) + AW'(PREFIX_BYTES - 1);
        end
        ST_SEND: if (tx_ready_i) begin
          if (ptr_q == last_q) state_q <= ST_WAIT;
          else                 ptr_q   <= ptr_q + AW'(1);
        end
        ST_WAIT: if (res_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o    = ptr_q;
  assign tx_valid_o   = (state_q == ST_SEND);
  // byte 1 goes out as the clamped length
  assign tx_data_o    = (ptr_q == AW'(1)) ? len_q : rdata_i;
  assign tx_last_o    = tx_valid_o && (ptr_q == last_q);
  assign frame_done_o = tx_last_o && tx_ready_i;
  assign res_take_o   = (state_q == ST_WAIT) && res_valid_i;
  assign busy_o       = (state_q != ST_IDLE);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  assert_clamp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && ptr_q == AW'(1) |-> tx_data_o <= MAX_LEN);
  assert_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !tx_valid_o);
  assert_no_early_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !res_take_o);
endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          busy_i,
  input  logic          frame_done_i,
  input  logic          res_take_i,
  input  logic          res_fail_i,
  output logic          start_o,
  output logic          ackreq_o,
  output logic          irq_no
);
  reg_sel_e      sel;
  logic          trig_q, ack_q, fail_q, done_q;
  logic [DW-1:0] mask_q;
  logic          ctrl_wr, istat_rd;

  assign sel      = reg_sel_e'(reg_sel_i);
  assign ctrl_wr  = reg_we_i && sel == SEL_CTRL && !busy_i;
  assign istat_rd = reg_re_i && sel == SEL_ISTAT;
  assign start_o  = ctrl_wr && reg_wdata_i[CTRL_TRIG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q      <= 1'b0;
      ack_q       <= 1'b0;
      fail_q      <= 1'b0;
      done_q      <= 1'b0;
      mask_q      <= DW'(1);
      reg_rdata_o <= '0;
    end else begin
      if (ctrl_wr) ack_q <= reg_wdata_i[CTRL_ACK_BIT];
      if (start_o) trig_q <= 1'b1;
      else if (frame_done_i) trig_q <= 1'b0;
      if (res_take_i) fail_q <= res_fail_i;
      // new completion wins over read-clear
      if (res_take_i) done_q <= 1'b1;
      else if (istat_rd) done_q <= 1'b0;
      if (reg_we_i && sel == SEL_IMASK) mask_q <= reg_wdata_i;
      if (reg_re_i) begin
        unique case (sel)
          SEL_CTRL: begin
            reg_rdata_o <= '0;
            reg_rdata_o[CTRL_TRIG_BIT] <= trig_q;
            reg_rdata_o[CTRL_ACK_BIT]  <= ack_q;
          end
          SEL_TXSTAT: reg_rdata_o <= DW'(fail_q);
          SEL_ISTAT:  reg_rdata_o <= DW'(done_q);
          default:    reg_rdata_o <= mask_q;
        endcase
      end
    end
  end

  assign ackreq_o = ack_q;
  assign irq_no   = ~(done_q & ~mask_q[0]);

  assert_trig_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> !trig_q);
  assert_trig_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> trig_q);
  assert_done_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_take_i |=> done_q);
  assert_done_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    istat_rd && !res_take_i |=> !done_q);
  assert_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[0] |-> irq_no);
  assert_ctrl_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !frame_done_i |=> $stable(ack_q));
endmodule

// File: rtl/txq_frame_ctrl.sv
module txq_frame_ctrl #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic [DW-1:0] buf_wdata_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_last_o,
  output logic          tx_ackreq_o,
  input  logic          res_valid_i,
  input  logic          res_fail_i,
  output logic          irq_no
);
  logic          busy, start, frame_done, res_take;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rdata, len_raw;

  txq_buf #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we_i && !busy),
    .waddr_i (buf_addr_i),
    .wdata_i (buf_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rdata),
    .len_o   (len_raw)
  );

  txq_stream #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_stream (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .len_raw_i    (len_raw),
    .rdata_i      (rdata),
    .rd_addr_o    (rd_addr),
    .tx_ready_i   (tx_ready_i),
    .res_valid_i  (res_valid_i),
    .tx_valid_o   (tx_valid_o),
    .tx_data_o    (tx_data_o),
    .tx_last_o    (tx_last_o),
    .frame_done_o (frame_done),
    .res_take_o   (res_take),
    .busy_o       (busy)
  );

  txq_regs #(.DW(DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_re_i     (reg_re_i),
    .reg_sel_i    (reg_sel_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .busy_i       (busy),
    .frame_done_i (frame_done),
    .res_take_i   (res_take),
    .res_fail_i   (res_fail_i),
    .start_o      (start),
    .ackreq_o     (tx_ackreq_o),
    .irq_no       (irq_no)
  );

  assert_start_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !busy);
  assert_result_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_take |=> !res_take);
endmodule

// File: tb/txq_frame_ctrl_bench.sv
module txq_frame_ctrl_bench;
  logic       clk = 0, rst_n = 0;
  logic       buf_we = 0, reg_we = 0, reg_re = 0, res_valid = 0, res_fail = 0;
  logic       tx_ready = 1;
  logic [6:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0, reg_wdata = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_rdata, tx_data;
  logic       tx_valid, tx_last, tx_ackreq, irq_n;

  int checks = 0, errors = 0, cycles = 0;
  bit ready_rand = 0;
  logic [7:0] lfsr = 8'h5a;

  // reference model state
  byte unsigned m_mem[128];
  byte unsigned q[$];
  bit m_send, m_wait, m_ack, m_fail, m_done, m_mask;
  int m_cnt;

  always #2 clk = ~clk;

  txq_frame_ctrl u_txq_frame_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ackreq_o(tx_ackreq),
    .res_valid_i(res_valid), .res_fail_i(res_fail), .irq_no(irq_n)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    bit busy, evt;
    int len;
    if (!rst_n) begin
      m_send = 0; m_wait = 0; m_ack = 0; m_fail = 0; m_done = 0; m_mask = 1;
      m_cnt = 0; q.delete();
      for (int i = 0; i < 128; i++) m_mem[i] = 0;
    end else begin
      busy = m_send || m_wait;
      evt  = m_wait && res_valid;
      if (m_send && tx_ready) begin
        void'(q.pop_front());
        m_cnt++;
        if (q.size() == 0) begin m_send = 0; m_wait = 1; end
      end
      if (evt) begin m_fail = res_fail; m_wait = 0; end
      if (reg_re && reg_sel == 2) m_done = 0;
      if (evt) m_done = 1;
      if (reg_we && reg_sel == 3) m_mask = reg_wdata[0];
      if (reg_we && reg_sel == 0 && !busy) begin
        m_ack = reg_wdata[2];
        if (reg_wdata[0]) begin
          len = (m_mem[1] > 126) ? 126 : m_mem[1];
          q.delete();
          q.push_back(m_mem[0]);
          q.push_back(8'(len));
          for (int i = 0; i < len; i++) q.push_back(m_mem[2+i]);
          m_send = 1; m_cnt = 0;
        end
      end
      if (buf_we && !busy) m_mem[buf_addr] = buf_wdata;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 valid", tx_valid, m_send);
      if (m_send) begin
        chk("R2 R3 R6 R10 data", tx_data, q[0]);
        chk("R2 last", tx_last, q.size() == 1);
      end
      chk("R4 R10 ackreq", tx_ackreq, m_ack);
      chk("R9 irq_no", irq_n, !(m_done && !m_mask));
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= ready_rand ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bw(int a, int d);
    @(negedge clk); buf_we = 1; buf_addr = 7'(a); buf_wdata = 8'(d);
    @(negedge clk); buf_we = 0;
  endtask

  task automatic rw(int s, int d);
    @(negedge clk); reg_we = 1; reg_sel = 2'(s); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int s, int exp, string tag);
    @(negedge clk); reg_re = 1; reg_sel = 2'(s);
    @(negedge clk); reg_re = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic res(bit f);
    @(negedge clk); res_valid = 1; res_fail = f;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic wait_result_phase();
    while (!m_wait) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq_no", irq_n, 1);
    chk("R1 valid", tx_valid, 0);
    rd(0, 0, "R1 ctrl");
    rd(1, 0, "R1 txstat");
    rd(2, 0, "R1 istat");
    rd(3, 1, "R1 mask");

    for (int i = 0; i < 128; i++) bw(i, (i * 7 + 3) & 255);
    rw(3, 0);

    // frame A: short, always ready, ack requested
    bw(0, 3); bw(1, 5);
    for (int i = 0; i < 5; i++) bw(2 + i, 8'hA0 + i);
    rw(0, 8'h05);
    wait_result_phase();
    rd(0, 8'h04, "R5 trigger cleared");
    res(0);
    @(negedge clk);
    chk("R9 irq asserted", irq_n, 0);
    rd(2, 1, "R8 istat set");
    rd(2, 0, "R8 istat cleared by read");
    chk("R9 irq released", irq_n, 1);
    rd(1, 0, "R7 success");

    // frame B: oversized length, random back-pressure, no ack
    bw(1, 200);
    ready_rand = 1;
    rw(0, 8'h01);
    rd(0, 8'h01, "R5 trigger held");
    res(0);              // ignored while sending
    bw(5, 8'hEE);        // ignored while busy
    rw(0, 8'h04);        // ignored while busy
    rd(0, 8'h01, "R10 ctrl write ignored");
    wait_result_phase();
    chk("R3 clamped byte count", m_cnt, 128);
    rd(2, 0, "R7 early result ignored");
    res(1);
    ready_rand = 0;
    rd(1, 1, "R7 retry exhausted");
    rd(2, 1, "R8 istat after fail");
    rd(0, 0, "R5 R10 ctrl after frame");

    // frame C: prefix only, interrupt masked
    rw(3, 1);
    bw(1, 0);
    rw(0, 8'h01);
    wait_result_phase();
    chk("R2 prefix-only length", m_cnt, 2);
    res(0);
    @(negedge clk);
    chk("R9 masked irq", irq_n, 1);
    rd(2, 1, "R8 masked istat");

    // frame D: result coincides with status read
    rw(3, 0);
    bw(1, 2);
    rw(0, 8'h05);
    wait_result_phase();
    @(negedge clk); res_valid = 1; res_fail = 0; reg_re = 1; reg_sel = 2;
    @(negedge clk); res_valid = 0; reg_re = 0;
    chk("R8 read returns old value", reg_rdata, 0);
    chk("R8 set wins over clear", irq_n, 0);
    rd(2, 1, "R8 istat kept");

    // result while idle
    res(1);
    rd(1, 0, "R7 idle result ignored");
    rd(2, 0, "R7 idle result no irq");
    chk("R4 ack retained", tx_ackreq, 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule